// File: doc/BRIEF.md
# Cache-Maintenance Permission Gate

This unit sits beside the issue path of cache-maintenance operations. For each issued operation it reads the operation's 2-bit permission code from the permission registers and the hart's current privilege mode. It then picks one of three outcomes: perform the operation, raise a trap so that machine-mode software can emulate or remap it, or retire it as a disabled operation. The chosen outcome appears on registered outputs one clock after the request.

A disabled operation is not a plain no-op. Range-style maintenance is run inside a software loop that advances a cursor held in the destination register. A disabled operation therefore still writes back a value that makes that loop end. An address-range operation gets its second source operand, the stop address. A cache-index operation gets zero. Issuing the cache action itself and sequencing trap entry are handled elsewhere.

Top module: `cacheop_perm_gate`

## Requirements
- R1: With permission code 2'b00 and class 0 (address-range), the cycle after a request shows `wb_valid`=1 with `wb_data` equal to the request's second operand, and `perform`=0, `trap`=0.
- R2: With permission code 2'b00 and class 1 (cache-index), the cycle after a request shows `wb_valid`=1 with `wb_data`=0, and `perform`=0, `trap`=0.
- R3: With permission code 2'b11 the operation is performed in every mode (user 2'b00, supervisor 2'b01, machine 2'b11). The cycle after shows `perform`=1 and no trap and no write-back.
- R4: With permission code 2'b01 and a mode other than machine (2'b11), the cycle after shows `trap`=1 and `trap_cause` equal to the request's operation index, with no perform and no write-back. Mode 2'b10 counts as below machine.
- R5: With permission code 2'b01 in machine mode (2'b11) the operation is performed.
- R6: Permission code 2'b10 behaves exactly like 2'b01: it traps below machine mode and is performed in machine mode.
- R7: The three outcome strobes are registered one cycle after `req_valid`. Exactly one of them is high after a valid request, none is high after a cycle without one, and back-to-back requests each get their own outcome.
- R8: While reset is asserted and after it is released, before any request, all outputs are zero.
- R9: `trap_cause` is zero whenever `trap` is low, and `wb_data` is zero whenever `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe: an operation is issued |
| req_perm | input | 2 | Permission code for this operation |
| req_mode | input | 2 | Current privilege mode (00 user, 01 supervisor, 11 machine) |
| req_class | input | 1 | 0 address-range, 1 cache-index |
| req_opidx | input | IDX_W | Operation index |
| req_stop | input | XLEN | Second source operand (stop address) |
| perform | output | 1 | Perform the cache action |
| trap | output | 1 | Raise a trap to machine mode |
| trap_cause | output | IDX_W | Operation index reported with the trap |
| wb_valid | output | 1 | Disabled completion: write destination |
| wb_data | output | XLEN | Loop-exit value for the destination |

## Verification
The properties assume that every request field is driven to a known value in a cycle where `req_valid` is high. They also assume that the issue side holds `req_valid` for exactly one cycle per operation, so each outcome cycle maps to a single request. The bench meets this by driving all request fields together on the falling edge, one cycle at a time, and dropping `req_valid` or replacing the request before the next rising edge. It samples outcomes on the following falling edge, so no check depends on the order of processes at an edge.

// File: rtl/cacheop_perm_pkg.sv
package cacheop_perm_pkg;

  typedef enum logic [1:0] {
    PERM_OFF  = 2'b00,
    PERM_TRAP = 2'b01,
    PERM_RSVD = 2'b10,
    PERM_OPEN = 2'b11
  } perm_code_e;

  typedef enum logic [1:0] {
    MODE_USER  = 2'b00,
    MODE_SUPER = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_MACH  = 2'b11
  } priv_mode_e;

  typedef enum logic {
    CLS_RANGE = 1'b0,
    CLS_INDEX = 1'b1
  } op_class_e;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'b00,
    OUT_PERFORM = 2'b01,
    OUT_TRAP    = 2'b10,
    OUT_DISABLE = 2'b11
  } outcome_e;

endpackage

// File: rtl/cacheop_perm_decide.sv
module cacheop_perm_decide
  import cacheop_perm_pkg::*;
(
  input  logic       valid_i,
  input  perm_code_e perm_i,
  input  priv_mode_e mode_i,
  output outcome_e   outcome_o
);

  logic is_machine;
  assign is_machine = (mode_i == MODE_MACH);

  always_comb begin
    outcome_o = OUT_NONE;
    if (valid_i) begin
      unique case (perm_i)
        PERM_OFF:  outcome_o = OUT_DISABLE;
        PERM_OPEN: outcome_o = OUT_PERFORM;
        // reserved code takes the same path as the trap code
        PERM_TRAP,
        PERM_RSVD: outcome_o = is_machine ? OUT_PERFORM : OUT_TRAP;
        default:   outcome_o = OUT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cacheop_perm_wbsel.sv
module cacheop_perm_wbsel
  import cacheop_perm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  op_class_e        class_i,
  input  logic [XLEN-1:0]  stop_i,
  output logic [XLEN-1:0]  exit_val_o
);

  // range loops exit when the cursor reaches the stop operand;
  // index loops exit when the cursor returns to zero
  always_comb begin
    unique case (class_i)
      CLS_RANGE: exit_val_o = stop_i;
      CLS_INDEX: exit_val_o = '0;
      default:   exit_val_o = '0;
    endcase
  end

endmodule

// File: rtl/cacheop_perm_outreg.sv
module cacheop_perm_outreg
  import cacheop_perm_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  outcome_e          outcome_i,
  input  logic [IDX_W-1:0]  opidx_i,
  input  logic [XLEN-1:0]   exit_val_i,
  output logic              perform_o,
  output logic              trap_o,
  output logic [IDX_W-1:0]  cause_o,
  output logic              wb_valid_o,
  output logic [XLEN-1:0]   wb_data_o
);

  logic             perform_d, trap_d, wb_valid_d;
  logic [IDX_W-1:0] cause_d;
  logic [XLEN-1:0]  wb_data_d;
  logic             busy_q;
  logic             upd_en;

  // registers only toggle while a request arrives or an outcome drains
  assign busy_q = perform_o | trap_o | wb_valid_o;
  assign upd_en = (outcome_i != OUT_NONE) | busy_q;

  always_comb begin
    perform_d  = (outcome_i == OUT_PERFORM);
    trap_d     = (outcome_i == OUT_TRAP);
    wb_valid_d = (outcome_i == OUT_DISABLE);
    cause_d    = trap_d     ? opidx_i    : '0;
    wb_data_d  = wb_valid_d ? exit_val_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perform_o  <= 1'b0;
      trap_o     <= 1'b0;
      wb_valid_o <= 1'b0;
      cause_o    <= '0;
      wb_data_o  <= '0;
    end else if (upd_en) begin
      perform_o  <= perform_d;
      trap_o     <= trap_d;
      wb_valid_o <= wb_valid_d;
      cause_o    <= cause_d;
      wb_data_o  <= wb_data_d;
    end
  end

endmodule

// File: rtl/cacheop_perm_gate.sv
module cacheop_perm_gate
  import cacheop_perm_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_perm,
  input  logic [1:0]        req_mode,
  input  logic              req_class,
  input  logic [IDX_W-1:0]  req_opidx,
  input  logic [XLEN-1:0]   req_stop,
  output logic              perform,
  output logic              trap,
  output logic [IDX_W-1:0]  trap_cause,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_data
);

  outcome_e        outcome;
  logic [XLEN-1:0] exit_val;

  cacheop_perm_decide u_decide (
    .valid_i   (req_valid),
    .perm_i    (perm_code_e'(req_perm)),
    .mode_i    (priv_mode_e'(req_mode)),
    .outcome_o (outcome)
  );

  cacheop_perm_wbsel #(.XLEN(XLEN)) u_wbsel (
    .class_i    (op_class_e'(req_class)),
    .stop_i     (req_stop),
    .exit_val_o (exit_val)
  );

  cacheop_perm_outreg #(.XLEN(XLEN), .IDX_W(IDX_W)) u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .outcome_i  (outcome),
    .opidx_i    (req_opidx),
    .exit_val_i (exit_val),
    .perform_o  (perform),
    .trap_o     (trap),
    .cause_o    (trap_cause),
    .wb_valid_o (wb_valid),
    .wb_data_o  (wb_data)
  );

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({perform, trap, wb_valid}));

  a_r7_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({perform, trap, wb_valid}) == 1);

  a_r7_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(perform | trap | wb_valid));

  a_r1_range_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_perm == 2'b00 && !req_class)
      |=> (wb_valid && wb_data == $past(req_stop)));

  a_r2_index_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_perm == 2'b00 && req_class)
      |=> (wb_valid && wb_data == '0));

  a_r3_open_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_perm == 2'b11) |=> perform);

  a_r4_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_perm[1] != req_perm[0] && req_mode != 2'b11)
      |=> (trap && trap_cause == $past(req_opidx)));

  a_r5_machine_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_perm[1] != req_perm[0] && req_mode == 2'b11) |=> perform);

  a_r9_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> trap_cause == '0);

  a_r9_wb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> wb_data == '0);

endmodule

// File: tb/cacheop_perm_gate_tb_top.sv
module cacheop_perm_gate_tb_top;

  localparam int XLEN  = 64;
  localparam int IDX_W = 8;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [1:0]       req_perm;
  logic [1:0]       req_mode;
  logic             req_class;
  logic [IDX_W-1:0] req_opidx;
  logic [XLEN-1:0]  req_stop;
  logic             perform, trap, wb_valid;
  logic [IDX_W-1:0] trap_cause;
  logic [XLEN-1:0]  wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  cacheop_perm_gate #(.XLEN(XLEN), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perm(req_perm),
    .req_mode(req_mode), .req_class(req_class), .req_opidx(req_opidx),
    .req_stop(req_stop), .perform(perform), .trap(trap),
    .trap_cause(trap_cause), .wb_valid(wb_valid), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic e_perf, input logic e_trap,
                       input logic e_wb, input logic [IDX_W-1:0] e_cause,
                       input logic [XLEN-1:0] e_data);
    n_checks++;
    if (perform !== e_perf || trap !== e_trap || wb_valid !== e_wb ||
        trap_cause !== e_cause || wb_data !== e_data) begin
      n_fail++;
      $display("FAIL %s: got perf=%b trap=%b wb=%b cause=%h data=%h, expected perf=%b trap=%b wb=%b cause=%h data=%h",
               tag, perform, trap, wb_valid, trap_cause, wb_data,
               e_perf, e_trap, e_wb, e_cause, e_data);
    end
  endtask

  // drive one request at the falling edge; after the next rising edge
  // the outcome is sampled on the following falling edge
  task automatic issue(input logic [1:0] perm, input logic [1:0] mode,
                       input logic cls, input logic [IDX_W-1:0] idx,
                       input logic [XLEN-1:0] stop);
    req_valid = 1'b1;
    req_perm  = perm;
    req_mode  = mode;
    req_class = cls;
    req_opidx = idx;
    req_stop  = stop;
    @(negedge clk);
  endtask

  task automatic go_idle();
    req_valid = 1'b0;
    req_perm  = 2'b00;
    req_mode  = 2'b00;
    req_class = 1'b0;
    req_opidx = '0;
    req_stop  = '0;
  endtask

  task automatic t_reset();
    go_idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 during reset", 0, 0, 0, '0, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 after release", 0, 0, 0, '0, '0);
  endtask

  task automatic t_disabled_range();
    issue(2'b00, 2'b00, 1'b0, 8'h11, 64'hDEAD_BEEF_0000_1000);
    check("R1 range user", 0, 0, 1, '0, 64'hDEAD_BEEF_0000_1000);
    issue(2'b00, 2'b11, 1'b0, 8'h12, 64'h0000_0000_0000_0040);
    check("R1 range machine", 0, 0, 1, '0, 64'h40);
    go_idle(); @(negedge clk);
    check("R7 R9 idle after disable", 0, 0, 0, '0, '0);
  endtask

  task automatic t_disabled_index();
    issue(2'b00, 2'b01, 1'b1, 8'h20, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 index exit zero", 0, 0, 1, '0, '0);
    go_idle(); @(negedge clk);
  endtask

  task automatic t_open();
    issue(2'b11, 2'b00, 1'b0, 8'h30, 64'h1234);
    check("R3 open user", 1, 0, 0, '0, '0);
    issue(2'b11, 2'b01, 1'b1, 8'h31, 64'h1234);
    check("R3 open supervisor", 1, 0, 0, '0, '0);
    issue(2'b11, 2'b11, 1'b0, 8'h32, 64'h1234);
    check("R3 open machine", 1, 0, 0, '0, '0);
    go_idle(); @(negedge clk);
  endtask

  task automatic t_trap();
    issue(2'b01, 2'b00, 1'b0, 8'hA5, 64'h99);
    check("R4 trap user", 0, 1, 0, 8'hA5, '0);
    issue(2'b01, 2'b01, 1'b1, 8'hFF, 64'h99);
    check("R4 trap supervisor", 0, 1, 0, 8'hFF, '0);
    issue(2'b01, 2'b10, 1'b0, 8'h01, 64'h99);
    check("R4 trap odd mode", 0, 1, 0, 8'h01, '0);
    issue(2'b01, 2'b11, 1'b0, 8'h02, 64'h99);
    check("R5 machine performs", 1, 0, 0, '0, '0);
    go_idle(); @(negedge clk);
    check("R9 cause cleared", 0, 0, 0, '0, '0);
  endtask

  task automatic t_reserved();
    issue(2'b10, 2'b00, 1'b1, 8'h7E, 64'h5);
    check("R6 reserved traps", 0, 1, 0, 8'h7E, '0);
    issue(2'b10, 2'b11, 1'b1, 8'h7F, 64'h5);
    check("R6 reserved machine performs", 1, 0, 0, '0, '0);
    go_idle(); @(negedge clk);
  endtask

  task automatic t_back_to_back();
    issue(2'b01, 2'b00, 1'b0, 8'h44, 64'h0);
    check("R7 b2b first trap", 0, 1, 0, 8'h44, '0);
    issue(2'b00, 2'b00, 1'b0, 8'h45, 64'hCAFE);
    check("R7 b2b then disable", 0, 0, 1, '0, 64'hCAFE);
    issue(2'b11, 2'b00, 1'b1, 8'h46, 64'h0);
    check("R7 b2b then perform", 1, 0, 0, '0, '0);
    go_idle(); @(negedge clk);
    check("R7 b2b drains", 0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    go_idle();
    @(negedge clk);
    t_reset();
    t_disabled_range();
    t_disabled_index();
    t_open();
    t_trap();
    t_reserved();
    t_back_to_back();
    finish_run();
  end

endmodule